// File: doc/BRIEF.md
# Flash Register Write Guard

This block sits between a 32-bit register bus and the configuration register file of a flash controller. It holds two flags: the protect flag in the control register and the write-violation error flag in the status register. For every bus write it decides, in the same cycle, whether to pass the write on to the register file behind it or to drop it. The register file and the erase and program sequencer sit outside this block. Reads always pass through. On the control and status addresses the block overlays its own flags onto the read data.

To change the protect flag, software must first write three key words. The first and third go to unlock register A and the second goes to unlock register B. Only after that may software write the control register. A key state machine tracks the sequence through four states:

- KEY_IDLE goes to KEY_FIRST on the first key.
- KEY_FIRST goes to KEY_SECOND on the second key.
- KEY_SECOND goes to KEY_OPEN on the third key.
- KEY_OPEN returns to KEY_IDLE on the next write, whatever it is.

Any write that is not the expected next key also sends the tracker back to KEY_IDLE. A dropped write raises the error flag. Software clears the flag by writing a one to it. The status register and the two unlock registers are never protected.

Top module: `flash_reg_guard`

## Requirements
- R1: After reset the protect flag (control bit 1) reads 1, the error flag (status bit 1) reads 0 and the key tracker is idle.
- R2: While the protect flag is 1, a write to any address other than control 0x00, status 0x2c, unlock A 0x18 or unlock B 0x1c is dropped (cfg_wr stays 0) and the error flag is 1 from the next cycle.
- R3: While the protect flag is 0, a write to such an address is forwarded in the same cycle: cfg_wr is 1 and cfg_addr and cfg_wdata equal the bus values.
- R4: The writes 0x00007123 to 0x18, then 0x0000812a to 0x1c, then 0x0000bee1 to 0x18, each compared on all 32 bits, open the key. The next write, if it goes to control, is forwarded and loads control bit 1 into the protect flag.
- R5: A wrong key value, a wrong address, or any other write in the middle of the sequence returns the tracker to idle, so a later control write without a full new sequence is not granted.
- R6: An open key grants exactly one write. Whatever that write is, the tracker returns to idle, and a second control write is not granted.
- R7: A control write without an open key whose bit 1 differs from the protect flag is dropped and sets the error flag, in either direction.
- R8: A control write without an open key, with the protect flag 0 and bit 1 equal to 0, is forwarded and leaves the flag unchanged. With the protect flag 1, such a write is dropped and sets the error flag.
- R9: A status write with bit 1 set clears the error flag. With bit 1 clear it leaves the flag unchanged. Status and unlock writes are never forwarded and never set the error flag, whatever the protect flag.
- R10: Reads are never blocked and never move the key tracker. cfg_rd follows bus_rd. bus_rdata equals cfg_rdata, except that bit 1 is replaced by the protect flag at 0x00 and by the error flag at 0x2c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data with flags overlaid |
| cfg_wr | output | 1 | Forwarded write strobe to register file |
| cfg_rd | output | 1 | Forwarded read strobe |
| cfg_addr | output | 8 | Forwarded offset |
| cfg_wdata | output | 32 | Forwarded write data |
| cfg_rdata | input | 32 | Read data from register file |
| ctrl_wp | output | 1 | Protect flag |
| wr_err | output | 1 | Write-violation error flag |

## Verification
The assertions assume at most one bus operation per cycle. They also assume that the bus inputs are settled before the clock edge, because the forwarding decision is combinational from bus_addr, bus_wdata and the stored flags. The stimulus changes the inputs only on the falling edge and issues writes and reads as separate operations. Sequences are broken on purpose at each position: a wrong value, a wrong register, and an unrelated write in the middle. This makes every transition of the key state machine fire, including the early returns to idle.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

    typedef enum logic [2:0] {
        CLS_CTRL,
        CLS_STAT,
        CLS_UNLK_A,
        CLS_UNLK_B,
        CLS_OTHER
    } reg_cls_e;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_FIRST,
        KEY_SECOND,
        KEY_OPEN
    } key_state_e;

    typedef enum logic [1:0] {
        WR_PASS,
        WR_DROP,
        WR_LOCAL
    } wr_fate_e;

endpackage

// File: rtl/flash_guard_decode.sv
module flash_guard_decode
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] OFS_CTRL   = 'h00,
    parameter logic [ADDR_W-1:0] OFS_STAT   = 'h2c,
    parameter logic [ADDR_W-1:0] OFS_UNLK_A = 'h18,
    parameter logic [ADDR_W-1:0] OFS_UNLK_B = 'h1c
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_cls_e          cls
);

    always_comb begin
        if (addr == OFS_CTRL)
            cls = CLS_CTRL;
        else if (addr == OFS_STAT)
            cls = CLS_STAT;
        else if (addr == OFS_UNLK_A)
            cls = CLS_UNLK_A;
        else if (addr == OFS_UNLK_B)
            cls = CLS_UNLK_B;
        else
            cls = CLS_OTHER;
    end

endmodule

// File: rtl/flash_guard_keyfsm.sv
module flash_guard_keyfsm
    import flash_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY_1 = 'h7123,
    parameter logic [DATA_W-1:0] KEY_2 = 'h812a,
    parameter logic [DATA_W-1:0] KEY_3 = 'hbee1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_cls_e          cls,
    input  logic [DATA_W-1:0] wdata,
    output logic              key_open
);

    key_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= KEY_IDLE;
        else
            state_q <= state_d;
    end

    // next state: any write other than the expected key returns to idle
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                KEY_IDLE:
                    state_d = (cls == CLS_UNLK_A && wdata == KEY_1) ? KEY_FIRST : KEY_IDLE;
                KEY_FIRST:
                    state_d = (cls == CLS_UNLK_B && wdata == KEY_2) ? KEY_SECOND : KEY_IDLE;
                KEY_SECOND:
                    state_d = (cls == CLS_UNLK_A && wdata == KEY_3) ? KEY_OPEN : KEY_IDLE;
                KEY_OPEN:
                    state_d = KEY_IDLE;
                default:
                    state_d = KEY_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        key_open = (state_q == KEY_OPEN);
    end

endmodule

// File: rtl/flash_guard_gate.sv
module flash_guard_gate
    import flash_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  reg_cls_e cls,
    input  logic     wp_bit_in,
    input  logic     wer_bit_in,
    input  logic     key_open,
    output logic     fwd,
    output logic     wp_q,
    output logic     wer_q
);

    wr_fate_e fate;

    always_comb begin
        unique case (cls)
            CLS_CTRL: begin
                if (key_open)
                    fate = WR_PASS;
                else if (wp_bit_in != wp_q)
                    fate = WR_DROP;
                else if (wp_q)
                    fate = WR_DROP;
                else
                    fate = WR_PASS;
            end
            CLS_STAT, CLS_UNLK_A, CLS_UNLK_B:
                fate = WR_LOCAL;
            CLS_OTHER:
                fate = wp_q ? WR_DROP : WR_PASS;
            default:
                fate = WR_DROP;
        endcase
    end

    always_comb begin
        fwd = wr_en && (fate == WR_PASS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= 1'b1;
            wer_q <= 1'b0;
        end else if (wr_en) begin
            if (cls == CLS_CTRL && key_open)
                wp_q <= wp_bit_in;
            if (fate == WR_DROP)
                wer_q <= 1'b1;
            else if (cls == CLS_STAT && wer_bit_in)
                wer_q <= 1'b0;
        end
    end

endmodule

// File: rtl/flash_reg_guard.sv
module flash_reg_guard
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int WP_BIT  = 1,
    parameter int WER_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cfg_wr,
    output logic              cfg_rd,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [DATA_W-1:0] cfg_wdata,
    input  logic [DATA_W-1:0] cfg_rdata,
    output logic              ctrl_wp,
    output logic              wr_err
);

    reg_cls_e bus_cls;
    logic     key_open;
    logic     fwd;

    flash_guard_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .cls  (bus_cls)
    );

    flash_guard_keyfsm #(.DATA_W(DATA_W)) u_keyfsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .cls      (bus_cls),
        .wdata    (bus_wdata),
        .key_open (key_open)
    );

    flash_guard_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .cls        (bus_cls),
        .wp_bit_in  (bus_wdata[WP_BIT]),
        .wer_bit_in (bus_wdata[WER_BIT]),
        .key_open   (key_open),
        .fwd        (fwd),
        .wp_q       (ctrl_wp),
        .wer_q      (wr_err)
    );

    always_comb begin
        cfg_wr    = fwd;
        cfg_rd    = bus_rd;
        cfg_addr  = bus_addr;
        cfg_wdata = bus_wdata;
        bus_rdata = cfg_rdata;
        if (bus_cls == CLS_CTRL)
            bus_rdata[WP_BIT] = ctrl_wp;
        else if (bus_cls == CLS_STAT)
            bus_rdata[WER_BIT] = wr_err;
    end

endmodule

// File: rtl/flash_reg_guard_chk.sv
module flash_reg_guard_chk
    import flash_guard_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     bus_wr,
    input logic     wbit,
    input reg_cls_e bus_cls,
    input logic     key_open,
    input logic     cfg_wr,
    input logic     ctrl_wp,
    input logic     wr_err
);

    assert_drop_protected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_wp && bus_cls == CLS_OTHER) |-> !cfg_wr);

    assert_drop_sets_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ctrl_wp && bus_cls == CLS_OTHER) |=> wr_err);

    assert_wp_needs_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_wp) |-> $past(bus_wr && bus_cls == CLS_CTRL && key_open));

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (key_open && bus_wr) |=> !key_open);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_err) |-> $past(bus_wr && bus_cls == CLS_STAT && wbit));

    assert_local_no_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_cls == CLS_STAT || bus_cls == CLS_UNLK_A || bus_cls == CLS_UNLK_B))
        |-> !cfg_wr);

    assert_fwd_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> bus_wr);

endmodule

bind flash_reg_guard flash_reg_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .wbit     (bus_wdata[1]),
    .bus_cls  (bus_cls),
    .key_open (key_open),
    .cfg_wr   (cfg_wr),
    .ctrl_wp  (ctrl_wp),
    .wr_err   (wr_err)
);

// File: tb/flash_reg_guard_tb.sv
module flash_reg_guard_tb;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_STAT = 8'h2c;
    localparam logic [7:0] A_UA   = 8'h18;
    localparam logic [7:0] A_UB   = 8'h1c;
    localparam logic [7:0] A_TIM  = 8'h04;
    localparam logic [7:0] A_ADR  = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        cfg_wr, cfg_rd;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = 32'h5a5a_c3c1;
    logic        ctrl_wp, wr_err;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // reference model
    bit m_wp = 1;
    bit m_wer = 0;
    int m_step = 0;

    always #4 clk = ~clk;

    flash_reg_guard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctrl_wp(ctrl_wp), .wr_err(wr_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // compare flags against the model on every clock
    always @(negedge clk) begin
        if (!done) begin
            check(cur_tag, {31'b0, ctrl_wp}, {31'b0, m_wp}, "protect flag");
            check(cur_tag, {31'b0, wr_err}, {31'b0, m_wer}, "error flag");
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
        bit exp_fwd;
        bit drop;
        int nxt;
        @(negedge clk);
        cur_tag   = tag;
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        exp_fwd = 0;
        drop = 0;
        if (a == A_CTRL) begin
            if (m_step == 3) exp_fwd = 1;
            else if (d[1] != m_wp || m_wp) drop = 1;
            else exp_fwd = 1;
        end else if (a == A_OTHER_CHECK(a)) begin
            if (m_wp) drop = 1;
            else exp_fwd = 1;
        end
        #1;
        check(tag, {31'b0, cfg_wr}, {31'b0, exp_fwd}, "forward strobe");
        if (exp_fwd) begin
            check(tag, {24'b0, cfg_addr}, {24'b0, a}, "forward addr");
            check(tag, cfg_wdata, d, "forward data");
        end
        @(posedge clk);
        #1;
        if (a == A_CTRL && m_step == 3) m_wp = d[1];
        if (drop) m_wer = 1;
        else if (a == A_STAT && d[1]) m_wer = 0;
        nxt = 0;
        if (m_step == 0 && a == A_UA && d == 32'h7123) nxt = 1;
        else if (m_step == 1 && a == A_UB && d == 32'h812a) nxt = 2;
        else if (m_step == 2 && a == A_UA && d == 32'hbee1) nxt = 3;
        m_step = nxt;
        bus_wr = 1'b0;
    endtask

    function automatic logic [7:0] A_OTHER_CHECK(logic [7:0] a);
        if (a == A_CTRL || a == A_STAT || a == A_UA || a == A_UB)
            return 8'hff;
        return a;
    endfunction

    task automatic rd(logic [7:0] a, string tag);
        logic [31:0] exp;
        @(negedge clk);
        cur_tag  = tag;
        bus_addr = a;
        bus_rd   = 1'b1;
        exp = cfg_rdata;
        if (a == A_CTRL) exp[1] = m_wp;
        else if (a == A_STAT) exp[1] = m_wer;
        #1;
        check(tag, bus_rdata, exp, "read data");
        check(tag, {31'b0, cfg_rd}, 32'd1, "read strobe");
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
    endtask

    task automatic unlock(string tag);
        wr(A_UA, 32'h7123, tag);
        wr(A_UB, 32'h812a, tag);
        wr(A_UA, 32'hbee1, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {31'b0, ctrl_wp}, 32'd1, "reset protect");
        check("R1", {31'b0, wr_err}, 32'd0, "reset error");
        rst_n = 1'b1;
        rd(A_CTRL, "R1");

        // protected write dropped
        wr(A_TIM, 32'h1234_5678, "R2");
        rd(A_STAT, "R10");
        cfg_rdata = 32'h0000_0002;
        rd(A_STAT, "R10");
        rd(A_TIM, "R10");
        cfg_rdata = 32'h5a5a_c3c1;
        wr(A_STAT, 32'h0, "R9");
        wr(A_STAT, 32'h2, "R9");

        // clearing protect without key
        wr(A_CTRL, 32'h0, "R7");
        wr(A_CTRL, 32'h2, "R8");
        wr(A_STAT, 32'h2, "R9");

        // full sequence with a read in the middle
        wr(A_UA, 32'h7123, "R4");
        rd(A_UB, "R10");
        wr(A_UB, 32'h812a, "R4");
        wr(A_UA, 32'hbee1, "R4");
        wr(A_CTRL, 32'h0, "R4");
        rd(A_CTRL, "R10");

        // grant used up
        wr(A_CTRL, 32'h2, "R6");
        wr(A_STAT, 32'h2, "R9");
        wr(A_CTRL, 32'h20, "R8");
        wr(A_ADR, 32'hcafe_0040, "R3");
        wr(A_TIM, 32'h0000_0007, "R3");

        // broken sequences
        wr(A_UA, 32'h7123, "R5");
        wr(A_UB, 32'h812b, "R5");
        wr(A_UA, 32'hbee1, "R5");
        wr(A_CTRL, 32'h2, "R5");
        wr(A_STAT, 32'h2, "R5");
        wr(A_UA, 32'h7123, "R5");
        wr(A_UB, 32'h812a, "R5");
        wr(A_STAT, 32'h0, "R5");
        wr(A_UA, 32'hbee1, "R5");
        wr(A_CTRL, 32'h2, "R5");
        wr(A_STAT, 32'h2, "R5");
        wr(A_UB, 32'h812a, "R5");
        wr(A_UA, 32'h7123, "R5");
        wr(A_UA, 32'hbee1, "R5");
        wr(A_CTRL, 32'h2, "R5");
        wr(A_STAT, 32'h2, "R5");

        // grant consumed by another write
        unlock("R6");
        wr(A_ADR, 32'h0000_0100, "R6");
        wr(A_CTRL, 32'h2, "R6");
        wr(A_STAT, 32'h2, "R6");

        // set protect again
        unlock("R4");
        wr(A_CTRL, 32'h2, "R4");
        wr(A_ADR, 32'h0000_0200, "R2");
        wr(A_STAT, 32'h2, "R9");
        wr(A_CTRL, 32'h2, "R8");
        wr(A_STAT, 32'h2, "R9");
        wr(A_UB, 32'h0, "R9");
        wr(A_STAT, 32'h0, "R9");
        rd(A_STAT, "R10");

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule